// File: doc/BRIEF.md
# System Clock Source Selector and Power-Up Reset Sequencer

This block drives a small microcontroller's system clock and core reset. Two oscillators feed it: an internal RC oscillator and one external clock line, which a crystal circuit or a direct clock can drive. The whole block runs in one fast clock domain. Each oscillator appears as a one-cycle tick input that marks one oscillator cycle. A configuration write picks the source and a divide ratio. The block then gives one system-clock enable pulse for every N ticks of the chosen source.

After power-on, the core reset stays asserted until a fixed number of RC oscillator ticks has been counted. Configuration writes made during that hold are dropped. New settings are held as pending and take effect only on a system-clock boundary, so no system period is ever cut short. A registered copy of the RC tick is passed out undivided for a watchdog timer, whatever source and divider are selected.

Top module: `clkrst_ctrl`

## Requirements
- R1: `src_sel` = 0 means the RC tick (`rc_tick`) feeds the divider. `src_sel` = 1 means the external tick (`ext_tick`) feeds it. A write stores `cfg_src` with the same meaning.
- R2: While `por_n` is low and right after it is released, `src_sel` = 0, `div_sel` = 2'b01, `core_rst_n` = 0 and `sys_en` = 0.
- R3: `core_rst_n` stays 0 until `HOLD_CYCLES` (default 65536) RC ticks have been sampled since `por_n` rose. Ticks on `ext_tick` do not count. `core_rst_n` reads 1 in the cycle after the clock edge that samples the last counted tick, and it then stays 1.
- R4: The divide code works as follows: 00 gives 1 pulse per source tick, 01 gives 1 per 2 ticks, 10 gives 1 per 4 ticks and 11 gives 1 per 8 ticks. `sys_en` is a one-cycle pulse, seen in the cycle after the edge that samples the Nth tick.
- R5: A write (`cfg_we` = 1 with `cfg_src`, `cfg_div`) becomes visible on `src_sel`/`div_sel` only in a cycle where `sys_en` = 1. The period that ends at the change is a full period under the old settings. The next period is a full period under the new settings.
- R6: Writes made while `core_rst_n` = 0 are ignored. After release, the defaults of R2 remain.
- R7: `wdt_tick` equals `rc_tick` delayed by one clock, whatever the source and divider settings.
- R8: Only ticks of the applied source advance the divider. With the external source selected and `ext_tick` idle, no `sys_en` pulse occurs even while `rc_tick` runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modelling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rc_tick | input | 1 | One pulse per internal RC oscillator cycle |
| ext_tick | input | 1 | One pulse per external (crystal or direct) clock cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Source to store: 0 RC, 1 external |
| cfg_div | input | 2 | Divide code to store |
| sys_en | output | 1 | System clock enable pulse |
| core_rst_n | output | 1 | Core reset, active low |
| wdt_tick | output | 1 | Undivided RC tick for the watchdog |
| src_sel | output | 1 | Applied source |
| div_sel | output | 2 | Applied divide code |

## Verification
Two functions can land in the same cycle: a period ending (a `sys_en` pulse) and the loading of a pending configuration. The bench provokes this by writing a new divide code just after a pulse in a slow divide-by-8 external setting. It then watches for the cycle in which `div_sel` changes. It judges that this cycle carries a pulse, that the period ending there is the full old length of 24 cycles, and that the following period has exactly the new length. The checker also watches every change of `src_sel` and `div_sel` and requires a pulse in the same cycle.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    // Width of the divide code; ratio is 2**code
    localparam int unsigned DIV_W    = 2;
    // Counter width able to hold the largest ratio minus one
    localparam int unsigned DIVCNT_W = (1 << DIV_W) - 1;

    typedef enum logic {
        SRC_RC  = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    typedef logic [DIV_W-1:0] div_code_t;

    localparam div_code_t DIV_CODE_RST = div_code_t'(1);

    typedef struct packed {
        clk_src_e  src;
        div_code_t div;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RST = '{src: SRC_RC, div: DIV_CODE_RST};

endpackage

// File: rtl/clkrst_por_hold.sv
module clkrst_por_hold #(
    parameter int unsigned HOLD_CYCLES = 65536
) (
    input  logic clk,
    input  logic por_n,
    input  logic rc_tick,
    output logic released
);

    localparam int unsigned CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done && rc_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign released = st_q.done;

endmodule

// File: rtl/clkrst_cfg.sv
module clkrst_cfg
    import clkrst_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     unlocked,
    input  logic     wr_en,
    input  clk_cfg_t wr_cfg,
    input  logic     boundary,
    output clk_cfg_t applied
);

    typedef struct packed {
        clk_cfg_t pend;
        logic     pend_vld;
        clk_cfg_t cur;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Load pending settings only where a period ends
        if (st_q.pend_vld && boundary) begin
            st_d.cur      = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        // Writes are dropped while the core is held in reset
        if (unlocked && wr_en) begin
            st_d.pend     = wr_cfg;
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.pend     <= CFG_RST;
            st_q.pend_vld <= 1'b0;
            st_q.cur      <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign applied = st_q.cur;

endmodule

// File: rtl/clkrst_divider.sv
module clkrst_divider
    import clkrst_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     rc_tick,
    input  logic     ext_tick,
    input  clk_cfg_t cfg,
    output logic     wrap,
    output logic     sys_en
);

    typedef struct packed {
        logic [DIVCNT_W-1:0] cnt;
        logic                pulse;
    } div_state_t;

    div_state_t          st_d, st_q;
    logic                sel_tick;
    logic [DIVCNT_W-1:0] last;
    logic                hit;

    always_comb begin
        sel_tick = (cfg.src == SRC_EXT) ? ext_tick : rc_tick;
        // Terminal count is 2**code - 1: a run of code ones
        for (int i = 0; i < int'(DIVCNT_W); i++) begin
            last[i] = (i < int'(cfg.div));
        end
        hit      = sel_tick && (st_q.cnt == last);
        st_d     = st_q;
        if (hit) begin
            st_d.cnt = '0;
        end else if (sel_tick) begin
            st_d.cnt = st_q.cnt + DIVCNT_W'(1);
        end
        st_d.pulse = hit;
        wrap       = hit;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_en = st_q.pulse;

endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 65536
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rc_tick,
    input  logic             ext_tick,
    input  logic             cfg_we,
    input  logic             cfg_src,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             sys_en,
    output logic             core_rst_n,
    output logic             wdt_tick,
    output logic             src_sel,
    output logic [DIV_W-1:0] div_sel
);

    logic     released;
    logic     wrap;
    clk_cfg_t wr_cfg;
    clk_cfg_t applied;
    logic     wdt_d, wdt_q;

    clkrst_por_hold #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) hold_i (
        .clk      (clk),
        .por_n    (por_n),
        .rc_tick  (rc_tick),
        .released (released)
    );

    always_comb begin
        wr_cfg.src = clk_src_e'(cfg_src);
        wr_cfg.div = cfg_div;
    end

    clkrst_cfg cfg_i (
        .clk      (clk),
        .por_n    (por_n),
        .unlocked (released),
        .wr_en    (cfg_we),
        .wr_cfg   (wr_cfg),
        .boundary (wrap),
        .applied  (applied)
    );

    clkrst_divider div_i (
        .clk      (clk),
        .por_n    (por_n),
        .rc_tick  (rc_tick),
        .ext_tick (ext_tick),
        .cfg      (applied),
        .wrap     (wrap),
        .sys_en   (sys_en)
    );

    // Undivided RC tick for the watchdog, one register deep
    always_comb begin
        wdt_d = rc_tick;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wdt_q <= 1'b0;
        end else begin
            wdt_q <= wdt_d;
        end
    end

    assign core_rst_n = released;
    assign wdt_tick   = wdt_q;
    assign src_sel    = applied.src;
    assign div_sel    = applied.div;

endmodule

// File: rtl/clkrst_ctrl_chk.sv
module clkrst_ctrl_chk
    import clkrst_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             rc_tick,
    input logic             ext_tick,
    input logic             sys_en,
    input logic             core_rst_n,
    input logic             wdt_tick,
    input logic             src_sel,
    input logic [DIV_W-1:0] div_sel
);

    // R3
    rst_stays_released_chk: assert property (@(posedge clk) disable iff (!por_n)
        core_rst_n |=> core_rst_n);

    // R6
    defaults_while_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |-> (src_sel == 1'b0 && div_sel == DIV_CODE_RST));

    // R5
    div_change_on_boundary_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(div_sel) |-> sys_en);

    // R5
    src_change_on_boundary_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(src_sel) |-> sys_en);

    // R8
    pulse_from_applied_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_en |-> $past(src_sel ? ext_tick : rc_tick));

    // R7
    wdt_follows_rc_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_tick == $past(rc_tick));

endmodule

bind clkrst_ctrl clkrst_ctrl_chk chk_i (
    .clk        (clk),
    .por_n      (por_n),
    .rc_tick    (rc_tick),
    .ext_tick   (ext_tick),
    .sys_en     (sys_en),
    .core_rst_n (core_rst_n),
    .wdt_tick   (wdt_tick),
    .src_sel    (src_sel),
    .div_sel    (div_sel)
);

// File: tb/clkrst_ctrl_tb_top.sv
module clkrst_ctrl_tb_top;

    localparam int HOLD = 65536;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rc_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_src = 1'b0;
    logic [1:0] cfg_div = 2'b00;
    logic       sys_en;
    logic       core_rst_n;
    logic       wdt_tick;
    logic       src_sel;
    logic [1:0] div_sel;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  rc_seen = 0;
    logic rc_last = 1'b0;
    int  rc_per = 1;
    int  ext_per = 3;
    int  rc_ph = 0;
    int  ext_ph = 0;
    bit  rc_run = 1'b0;

    clkrst_ctrl #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .rc_tick    (rc_tick),
        .ext_tick   (ext_tick),
        .cfg_we     (cfg_we),
        .cfg_src    (cfg_src),
        .cfg_div    (cfg_div),
        .sys_en     (sys_en),
        .core_rst_n (core_rst_n),
        .wdt_tick   (wdt_tick),
        .src_sel    (src_sel),
        .div_sel    (div_sel)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rc_last <= rc_tick;
        if (por_n && rc_tick) rc_seen <= rc_seen + 1;
    end

    // Tick generators, driven just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rc_run && por_n && rc_per > 0) begin
                rc_ph   = (rc_ph + 1) % rc_per;
                rc_tick = (rc_ph == 0);
            end else begin
                rc_tick = 1'b0;
            end
            if (por_n && ext_per > 0) begin
                ext_ph   = (ext_ph + 1) % ext_per;
                ext_tick = (ext_ph == 0);
            end else begin
                ext_tick = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic src, input logic [1:0] div);
        @(posedge clk);
        #1;
        cfg_we  = 1'b1;
        cfg_src = src;
        cfg_div = div;
        @(posedge clk);
        #1;
        cfg_we  = 1'b0;
    endtask

    // Measure cycles between two consecutive pulses
    task automatic gap_check(input int exp, input string req);
        int c0;
        do @(negedge clk); while (!sys_en);
        c0 = cyc;
        do @(negedge clk); while (!sys_en);
        check(cyc - c0 == exp, req, "pulse spacing", cyc - c0, exp);
    endtask

    task automatic t_power_up();
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(core_rst_n == 1'b0, "R2", "core_rst_n in por", int'(core_rst_n), 0);
        check(src_sel == 1'b0, "R2", "src_sel in por", int'(src_sel), 0);
        check(div_sel == 2'b01, "R2", "div_sel in por", int'(div_sel), 1);
        check(sys_en == 1'b0, "R2", "sys_en in por", int'(sys_en), 0);
        @(posedge clk);
        #1;
        por_n  = 1'b1;
        rc_run = 1'b1;
        rc_per = 1;
        // R6: writes during the hold must be dropped
        write_cfg(1'b1, 2'b00);
        repeat (100) @(posedge clk);
        write_cfg(1'b1, 2'b11);
        // R3: external ticks alone must not advance the hold
        rc_run = 1'b0;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(core_rst_n == 1'b0, "R3", "held with rc idle", int'(core_rst_n), 0);
        rc_run = 1'b1;
        while (rc_seen < HOLD - 1) @(negedge clk);
        check(core_rst_n == 1'b0, "R3", "held one tick early", int'(core_rst_n), 0);
        @(negedge clk);
        check(rc_seen == HOLD, "R3", "tick count", rc_seen, HOLD);
        check(core_rst_n == 1'b1, "R3", "released after hold", int'(core_rst_n), 1);
        repeat (20) @(negedge clk);
        check(src_sel == 1'b0, "R6", "src_sel after held writes", int'(src_sel), 0);
        check(div_sel == 2'b01, "R6", "div_sel after held writes", int'(div_sel), 1);
        check(core_rst_n == 1'b1, "R3", "stays released", int'(core_rst_n), 1);
    endtask

    task automatic t_rc_ratios();
        gap_check(2, "R4 rc div2 default");
        write_cfg(1'b0, 2'b00);
        repeat (20) @(posedge clk);
        gap_check(1, "R4 rc div1");
        gap_check(1, "R4 rc div1");
        write_cfg(1'b0, 2'b10);
        repeat (20) @(posedge clk);
        gap_check(4, "R4 rc div4");
        write_cfg(1'b0, 2'b11);
        repeat (30) @(posedge clk);
        gap_check(8, "R4 rc div8");
        gap_check(8, "R4 rc div8");
    endtask

    task automatic t_ext_source();
        ext_per = 3;
        rc_per  = 2;
        write_cfg(1'b1, 2'b11);
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(src_sel == 1'b1, "R1", "src_sel external", int'(src_sel), 1);
        gap_check(24, "R1 ext div8");
        gap_check(24, "R4 ext div8");
    endtask

    task automatic t_boundary_change();
        int c0;
        logic [1:0] prev;
        do @(negedge clk); while (!sys_en);
        c0   = cyc;
        prev = div_sel;
        write_cfg(1'b1, 2'b00);
        do @(negedge clk); while (div_sel == prev);
        check(sys_en == 1'b1, "R5", "pulse at change", int'(sys_en), 1);
        check(cyc - c0 == 24, "R5", "old period kept whole", cyc - c0, 24);
        c0 = cyc;
        do @(negedge clk); while (!sys_en);
        check(cyc - c0 == 3, "R5", "first new period", cyc - c0, 3);
    endtask

    task automatic t_applied_only();
        int pulses = 0;
        ext_per = 0;
        rc_per  = 1;
        repeat (4) @(posedge clk);
        repeat (40) begin
            @(negedge clk);
            if (sys_en) pulses++;
        end
        check(pulses == 0, "R8", "pulses with ext idle", pulses, 0);
        ext_per = 3;
    endtask

    task automatic t_watchdog_tick();
        int bad = 0;
        rc_per = 2;
        repeat (60) begin
            @(negedge clk);
            if (wdt_tick !== rc_last) bad++;
        end
        check(bad == 0, "R7", "wdt_tick mismatches", bad, 0);
    endtask

    task automatic t_back_to_rc();
        rc_per = 1;
        write_cfg(1'b0, 2'b01);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(src_sel == 1'b0, "R1", "src_sel back to rc", int'(src_sel), 0);
        gap_check(2, "R1 rc div2 again");
    endtask

    initial begin
        fork
            begin
                t_power_up();
                t_rc_ratios();
                t_ext_source();
                t_boundary_change();
                t_applied_only();
                t_watchdog_tick();
                t_back_to_rc();
            end
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "WATCHDOG", "run timed out", cyc, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule